// File: doc/BRIEF.md
# Single-Bit Stream Decimating CIC Filter

This block turns a one-bit oversampled stream, such as the comparator output of a sigma-delta modulator, into signed 8-bit samples at a rate 64 times lower. The serial bit arrives with no timing relation to the block's clock. It first crosses a two-flop synchronizer, so that no adder ever sees it change inside a clock cycle. Each synchronized bit then counts as +1 (bit high) or -1 (bit low) and feeds a chain of three integrators that run on every fast clock edge.

A decimation sequencer counts fast cycles from 0 to 63. On the last count of each period it moves the newest value of the third integrator into a three-stage comb section (differential delay of one decimated sample). It also registers the scaled and clipped comb result as the output sample. The sequencer has two named states. ST_GATHER is the state it rests in while the counter runs. It moves from ST_GATHER to ST_EMIT on the cycle where the counter wraps (transition "wrap"). It always moves back from ST_EMIT to ST_GATHER after one cycle (transition "release"). The sample-valid strobe is high exactly while the sequencer is in ST_EMIT.

Internal registers are 20 bits wide and wrap in two's complement. The filter gain is 64^3 = 2^18, so the comb result spans -2^18 to +2^18. The output keeps the comb result divided by 2^11, rounded toward minus infinity. The one value that would need 9 bits, +128, is clipped to +127.

Top module: `bitstream_decimator`

## Requirements
- R1: The serial input passes through two clock-edge register stages before it reaches the first integrator. A change of `bit_in` that is sampled at edge k first affects the integrators at edge k+2.
- R2: The first integrator adds +1 for a synchronized bit of 1 and -1 for a bit of 0 on every edge. The second and third integrators each add the previous value of the stage before them. All three wrap modulo 2^20.
- R3: `sample_valid` is high for exactly one clock cycle per 64 fast cycles, and consecutive pulses are exactly 64 cycles apart.
- R4: After reset is released, the first `sample_valid` pulse appears in the cycle after the 64th rising edge. That is the edge at which the decimation counter first wraps from 63 to 0.
- R5: At each wrap the comb section computes three first differences of the third integrator against its value at the previous wrap. `sample_out` (two's complement, bit 7 the sign) becomes floor(comb / 2048), clipped to the range -128..+127. It changes only in the cycle where `sample_valid` is high.
- R6: A constant 1 input settles to `sample_out` = +127 (0x7F). A constant 0 input settles to -128 (0x80).
- R7: An alternating 1/0 input settles to a `sample_out` within ±2 of zero.
- R8: Synchronous reset clears the synchronizer, integrators, comb delays, counter and output. During reset and until the first pulse afterwards, `sample_out` = 0 and `sample_valid` = 0.
- R9: Over long runs in which the integrators wrap many times, every output sample still equals the exact filter result of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Asynchronous oversampled one-bit stream |
| sample_out | output | 8 | Signed decimated sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench drives constant-1 and constant-0 streams to reach both ends of the output range. A design that keeps the nominal 19-bit width, or drops the clip, wraps full positive scale to -128 instead of +127. An alternating stream exposes a wrong comb delay or a missing integrator stage as a large non-zero output. Random streams of varying density run long enough for the integrators to wrap many times. They catch a missing or extra synchronizer flop as a sample-by-sample mismatch, because the one-cycle shift changes which bits fall into each period. A reset in the middle of a run, with the timing of the first pulse afterwards, exposes an off-by-one counter or state left over from before the reset.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    // Decimation sequencer states
    typedef enum logic {
        ST_GATHER = 1'b0,
        ST_EMIT   = 1'b1
    } seq_state_t;

endpackage

// File: rtl/bsd_sync.sv
module bsd_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [DEPTH-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flop
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[DEPTH-1];
endmodule

// File: rtl/bsd_integrators.sv
module bsd_integrators #(
    parameter int W = 20,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_in,
    output logic signed [W-1:0] acc_out
);
    localparam logic signed [W-1:0] STEP_UP = W'(1);
    localparam logic signed [W-1:0] STEP_DN = {W{1'b1}};

    logic signed [W-1:0] acc [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) acc[0] <= '0;
                    else     acc[0] <= acc[0] + (bit_in ? STEP_UP : STEP_DN);
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) acc[g] <= '0;
                    else     acc[g] <= acc[g] + acc[g-1];
                end
            end
        end
    endgenerate

    assign acc_out = acc[N-1];

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((acc[0] - $past(acc[0])) == STEP_UP) ||
                         ((acc[0] - $past(acc[0])) == STEP_DN))); // R2
endmodule

// File: rtl/bsd_combs.sv
module bsd_combs #(
    parameter int W = 20,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic signed [W-1:0] comb_in,
    output logic signed [W-1:0] comb_out
);
    logic signed [W-1:0] tap  [N+1];
    logic signed [W-1:0] hist [N];

    assign tap[0] = comb_in;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            assign tap[g+1] = tap[g] - hist[g];
            always_ff @(posedge clk) begin
                if (rst)       hist[g] <= '0;
                else if (load) hist[g] <= tap[g];
            end
        end
    endgenerate

    assign comb_out = tap[N];
endmodule

// File: rtl/bsd_sequencer.sv
module bsd_sequencer #(
    parameter int DECIM = 64
) (
    input  logic clk,
    input  logic rst,
    output logic dump,
    output logic emit
);
    import bsd_pkg::*;

    localparam int             CW   = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0]  LAST = CW'(DECIM - 1);

    seq_state_t     state, state_nx;
    logic [CW-1:0]  cnt;

    // State and counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GATHER;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GATHER: state_nx = dump ? ST_EMIT : ST_GATHER;   // wrap
            ST_EMIT:   state_nx = dump ? ST_EMIT : ST_GATHER;   // release
            default:   state_nx = ST_GATHER;
        endcase
    end

    // Outputs
    always_comb begin
        dump = (cnt == LAST);
        emit = (state == ST_EMIT);
    end

    AST_EMIT_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        dump |=> emit); // R3

    AST_EMIT_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        emit |-> (cnt == '0)); // R4
endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator #(
    parameter int DECIM      = 64,
    parameter int STAGES     = 3,
    parameter int OUT_W      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sample_valid
);
    localparam int RATE_LOG = $clog2(DECIM);
    localparam int GAIN_LOG = STAGES * RATE_LOG;
    localparam int ACC_W    = 2 + GAIN_LOG;
    localparam int SHIFT    = GAIN_LOG - (OUT_W - 1);
    localparam int SH_W     = ACC_W - SHIFT;
    localparam logic signed [SH_W-1:0] TOP_V = SH_W'((1 <<< (OUT_W-1)) - 1);
    localparam logic signed [SH_W-1:0] BOT_V = -SH_W'(1 <<< (OUT_W-1));

    logic                    bit_sync;
    logic signed [ACC_W-1:0] integ_out;
    logic signed [ACC_W-1:0] comb_out;
    logic                    dump;
    logic                    emit;
    logic signed [SH_W-1:0]  scaled;
    logic signed [OUT_W-1:0] clipped;

    bsd_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_in(bit_in), .sync_out(bit_sync)
    );

    bsd_integrators #(.W(ACC_W), .N(STAGES)) u_integ (
        .clk(clk), .rst(rst), .bit_in(bit_sync), .acc_out(integ_out)
    );

    bsd_sequencer #(.DECIM(DECIM)) u_seq (
        .clk(clk), .rst(rst), .dump(dump), .emit(emit)
    );

    bsd_combs #(.W(ACC_W), .N(STAGES)) u_comb (
        .clk(clk), .rst(rst), .load(dump), .comb_in(integ_out), .comb_out(comb_out)
    );

    // Floor division by 2^SHIFT is a plain slice; clip the single overflow code
    always_comb begin
        scaled = comb_out[ACC_W-1:SHIFT];
        if (scaled > TOP_V)      clipped = TOP_V[OUT_W-1:0];
        else if (scaled < BOT_V) clipped = BOT_V[OUT_W-1:0];
        else                     clipped = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       sample_out <= '0;
        else if (dump) sample_out <= clipped;
    end

    assign sample_valid = emit;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid); // R3

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> $stable(sample_out)); // R5
endmodule

// File: tb/bitstream_decimator_test.sv
module bitstream_decimator_test;
    localparam int ACC_W = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic signed [7:0] sample_out;
    logic       sample_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bitstream_decimator uut (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .sample_out(sample_out), .sample_valid(sample_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic signed [7:0] expect_sample(input logic signed [ACC_W-1:0] y);
        int v;
        v = int'(y) >>> 11;
        if (v > 127)  v = 127;
        if (v < -128) v = -128;
        return 8'(v);
    endfunction

    // Reference filter, built from R1, R2, R4, R5
    logic m_s1, m_s2;
    logic signed [ACC_W-1:0] m_i1, m_i2, m_i3, m_d1, m_d2, m_d3;
    int   m_cnt;
    logic m_vld;
    logic signed [7:0] m_out;

    always @(posedge clk) begin
        logic signed [ACC_W-1:0] n1, n2, n3, y0, y1, y2, y3;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_i1 = 0; m_i2 = 0; m_i3 = 0;
            m_d1 = 0; m_d2 = 0; m_d3 = 0; m_cnt = 0; m_vld = 0; m_out = 0;
        end else begin
            n1 = m_i1 + (m_s2 ? 20'sd1 : -20'sd1);
            n2 = m_i2 + m_i1;
            n3 = m_i3 + m_i2;
            if (m_cnt == 63) begin
                y0 = m_i3; y1 = y0 - m_d1; y2 = y1 - m_d2; y3 = y2 - m_d3;
                m_d1 = y0; m_d2 = y1; m_d3 = y2;
                m_out = expect_sample(y3);
                m_vld = 1;
            end else begin
                m_vld = 0;
            end
            m_cnt = (m_cnt + 1) % 64;
            m_s2 = m_s1; m_s1 = bit_in;
            m_i1 = n1; m_i2 = n2; m_i3 = n3;
        end
    end

    // Monitor: sampled 1 ns after each rising edge
    int   cyc = 0, last_cyc = 0, since_rst = 0;
    bit   first_pending = 1'b1, seen_one = 1'b0;
    logic signed [7:0] last_out = 0;

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst) begin
            since_rst = 0;
            first_pending = 1'b1;
            seen_one = 1'b0;
        end else begin
            since_rst++;
            check(sample_valid == m_vld, "R3 valid timing", sample_valid, m_vld);
            if (sample_valid) begin
                check(sample_out == m_out, "R5/R1/R2/R9 sample value", sample_out, m_out);
                if (first_pending) begin
                    check(since_rst == 64, "R4 first pulse edge", since_rst, 64);
                    first_pending = 1'b0;
                end
                if (seen_one)
                    check(cyc - last_cyc == 64, "R3 pulse spacing", cyc - last_cyc, 64);
                seen_one = 1'b1;
                last_cyc = cyc;
                last_out = sample_out;
            end else if (first_pending) begin
                check(sample_out == 0, "R8 output cleared before first pulse", sample_out, 0);
            end
        end
    end

    task automatic run_const(input logic b, input int n_samp);
        bit_in = b;
        repeat (n_samp * 64) @(negedge clk);
    endtask

    task automatic run_alt(input int n_samp);
        for (int k = 0; k < n_samp * 64; k++) begin
            bit_in = k[0];
            @(negedge clk);
        end
    endtask

    task automatic run_random(input int n_samp);
        for (int s = 0; s < n_samp; s++) begin
            int dens;
            dens = $urandom_range(0, 100);
            for (int k = 0; k < 64; k++) begin
                bit_in = ($urandom_range(0, 99) < dens);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20061026));
        repeat (4) @(negedge clk);
        check(sample_out == 0,   "R8 reset output",  sample_out, 0);
        check(sample_valid == 0, "R8 reset valid",   sample_valid, 0);
        rst = 1'b0;

        run_const(1'b1, 10);
        check(last_out == 127, "R6 constant one full scale", last_out, 127);

        run_const(1'b0, 10);
        check(last_out == -128, "R6 constant zero full scale", last_out, -128);

        run_alt(10);
        check(last_out >= -2 && last_out <= 2, "R7 alternating near zero", last_out, 0);

        run_random(200);

        // Reset in mid-run
        bit_in = 1'b1;
        repeat (17) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sample_out == 0,   "R8 mid-run reset output", sample_out, 0);
        check(sample_valid == 0, "R8 mid-run reset valid",  sample_valid, 0);
        rst = 1'b0;
        run_random(20);
        run_const(1'b1, 8);
        check(last_out == 127, "R6 full scale after reset", last_out, 127);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule